// File: doc/BRIEF.md
# FIFO Flag Offset Register Port

This block holds the two programmable thresholds that a FIFO's almost-empty and almost-full flag logic compares against. Software programs and inspects them through the FIFO's own data buses: while the load select input is high, a write-side access stores the low bits of the write data into an offset register, and a read-side access returns an offset register on the read data bus instead of a FIFO word.

Each side keeps its own register pointer. The write pointer steps on every accepted write, and the read pointer steps on every accepted readback. Both pointers visit the almost-empty offset first and the almost-full offset second, then wrap to the first. Readback is allowed only in standard mode. When the FIFO runs in first-word-fall-through mode, readback is suppressed and the read pointer does not move. Software must keep reads and writes of the offsets apart in time. An overlap of the two gives an undefined result.

Top module: `flag_ofs_port`

## Requirements
- R1: After reset both pointers select the almost-empty offset (index 0), both offsets hold DEPTH/8-1 (31 for DEPTH=256), and rdata_o is zero.
- R2: On a rising clk_w_i with load_i=1 and wr_en_i=1, the offset at the write pointer takes wdata_i[AW-1:0] (AW=$clog2(DEPTH), 8 by default). The other offset is unchanged.
- R3: Each accepted write advances the write pointer in the order index 0 (almost-empty) then index 1 (almost-full), wrapping back to index 0.
- R4: A write clock edge with load_i=0 or wr_en_i=0 changes no offset and does not move the write pointer.
- R5: On a rising clk_r_i with load_i=1, rd_en_i=1 and fwft_i=0, rdata_o takes the offset at the read pointer in bits [AW-1:0], with zeros above.
- R6: Each accepted readback advances the read pointer in the same order and with the same wrap as the write pointer.
- R7: The read pointer moves only on accepted readbacks and the write pointer only on accepted writes. Neither pointer affects the other.
- R8: With fwft_i=1 a readback request leaves rdata_o unchanged and does not move the read pointer.
- R9: A read clock edge with load_i=0 or rd_en_i=0 leaves rdata_o and the read pointer unchanged.
- R10: empty_ofs_o and full_ofs_o always present the stored almost-empty and almost-full offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w_i | input | 1 | Write clock |
| clk_r_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Select offset registers instead of FIFO memory |
| wr_en_i | input | 1 | Write enable |
| wdata_i | input | DW (18) | Write data bus |
| rd_en_i | input | 1 | Read enable |
| fwft_i | input | 1 | First-word-fall-through mode; blocks readback |
| rdata_o | output | DW (18) | Read data bus carrying the readback |
| empty_ofs_o | output | AW (8) | Almost-empty offset to the flag logic |
| full_ofs_o | output | AW (8) | Almost-full offset to the flag logic |

## Verification
A stuck or skipped write pointer sends the next write into the wrong offset, and empty_ofs_o or full_ofs_o shows this one write-clock cycle later. A wrong read pointer returns the other offset on rdata_o at the next accepted readback. If the read pointer moves while fwft_i is high, every later readback is off by one register. The bench mixes enables, load select and mode at random, so any divergence shows within a few operations.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;
  localparam int unsigned NREG      = 2;
  localparam int unsigned IDX_EMPTY = 0;
  localparam int unsigned IDX_FULL  = 1;

  function automatic int unsigned def_ofs(input int unsigned depth);
    return depth / 8 - 1;
  endfunction
endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr #(
  parameter int unsigned NREG = 2,
  localparam int unsigned PW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(NREG - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (step_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  p_step_moves_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ptr_o != $past(ptr_o));
  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(ptr_o));
  p_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST);
endmodule

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    wr_en_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [NREG-1:0][AW-1:0] regs_o
);
  localparam logic [AW-1:0] RST_VAL = AW'(def_ofs(DEPTH));

  logic          wr_go;
  logic [PW-1:0] wptr;
  logic [DW-AW-1:0] unused_hi;

  assign wr_go     = load_i & wr_en_i;
  assign unused_hi = wdata_i[DW-1:AW];

  ofs_ptr #(.NREG(NREG)) u_wptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (wr_go),
    .ptr_o  (wptr)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         regs_o[g] <= RST_VAL;
      else if (wr_go && wptr == PW'(g))    regs_o[g] <= wdata_i[AW-1:0];
    end
  end

  p_no_write_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_go |=> $stable(regs_o));
  p_empty_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && wptr == PW'(IDX_EMPTY)) |=> regs_o[IDX_EMPTY] == $past(wdata_i[AW-1:0]));
  p_full_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && wptr == PW'(IDX_FULL)) |=>
      (regs_o[IDX_FULL] == $past(wdata_i[AW-1:0])) && $stable(regs_o[IDX_EMPTY]));
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    rd_en_i,
  input  logic                    fwft_i,
  input  logic [NREG-1:0][AW-1:0] regs_i,
  output logic [DW-1:0]           rdata_o
);
  logic          rd_go;
  logic [PW-1:0] rptr;

  // readback only in standard mode
  assign rd_go = load_i & rd_en_i & ~fwft_i;

  ofs_ptr #(.NREG(NREG)) u_rptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (rd_go),
    .ptr_o  (rptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_go) rdata_o <= {{(DW-AW){1'b0}}, regs_i[rptr]};
  end

  p_fwft_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwft_i |=> $stable(rdata_o) && $stable(rptr));
  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:AW] == '0);
  p_idle_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && rd_en_i) |=> $stable(rdata_o));
endmodule

// File: rtl/flag_ofs_port.sv
module flag_ofs_port
  import flag_ofs_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 18,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_w_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic          fwft_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] empty_ofs_o,
  output logic [AW-1:0] full_ofs_o
);
  logic [NREG-1:0][AW-1:0] regs;

  ofs_wr_side #(.DEPTH(DEPTH), .DW(DW)) u_wr (
    .clk_i   (clk_w_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  // offsets are static while read side accesses them (no concurrent access)
  ofs_rd_side #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk_i   (clk_r_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .rd_en_i (rd_en_i),
    .fwft_i  (fwft_i),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  assign empty_ofs_o = regs[IDX_EMPTY];
  assign full_ofs_o  = regs[IDX_FULL];
endmodule

// File: tb/tb_flag_ofs_port.sv
module tb_flag_ofs_port;
  localparam int DEPTH = 256;
  localparam int DW    = 18;
  localparam int AW    = 8;

  logic clk_w = 0, clk_r = 0, rst_n = 0;
  logic load = 0, wr_en = 0, rd_en = 0, fwft = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [AW-1:0] e_ofs, f_ofs;

  int total = 0, bad = 0;
  bit done = 0;

  logic [AW-1:0] m_reg [2];
  int            m_wp, m_rp;
  logic [DW-1:0] m_q;

  always #2 clk_w = ~clk_w;
  initial begin #1; forever #2 clk_r = ~clk_r; end

  flag_ofs_port #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk_w_i(clk_w), .clk_r_i(clk_r), .rst_ni(rst_n),
    .load_i(load), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .fwft_i(fwft),
    .rdata_o(rdata), .empty_ofs_o(e_ofs), .full_ofs_o(f_ofs)
  );

  function automatic int nxt(input int p);
    return (p == 1) ? 0 : p + 1;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req);
    chk({req, " R10 empty"}, DW'(e_ofs), DW'(m_reg[0]));
    chk({req, " R10 full"},  DW'(f_ofs), DW'(m_reg[1]));
  endtask

  task automatic do_wr(input logic ld, input logic en, input logic [DW-1:0] d, input string req);
    @(negedge clk_w);
    load = ld; wr_en = en; wdata = d;
    @(negedge clk_w);
    load = 0; wr_en = 0;
    if (ld && en) begin
      m_reg[m_wp] = d[AW-1:0];
      m_wp = nxt(m_wp);
    end
    chk_ofs(req);
  endtask

  task automatic do_rd(input logic ld, input logic en, input logic fw, input string req);
    @(negedge clk_r);
    load = ld; rd_en = en; fwft = fw;
    @(negedge clk_r);
    load = 0; rd_en = 0; fwft = 0;
    if (ld && en && !fw) begin
      m_q = {{(DW-AW){1'b0}}, m_reg[m_rp]};
      m_rp = nxt(m_rp);
    end
    chk(req, rdata, m_q);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    m_reg[0] = AW'(DEPTH/8 - 1);
    m_reg[1] = AW'(DEPTH/8 - 1);
    m_wp = 0; m_rp = 0; m_q = '0;
    #7 rst_n = 1;
    @(negedge clk_w);
    // R1 reset state
    chk("R1 empty default", DW'(e_ofs), DW'(31));
    chk("R1 full default",  DW'(f_ofs), DW'(31));
    chk("R1 rdata", rdata, '0);
    do_rd(1, 1, 0, "R1 first read is empty ofs");
    do_rd(1, 1, 0, "R6 second read is full ofs");
    // R2/R3 ordered writes with wrap, upper bits dropped
    do_wr(1, 1, 18'h3ffa5, "R2 write empty");
    do_wr(1, 1, 18'h2003c, "R3 write full");
    do_wr(1, 1, 18'h00077, "R3 wrap to empty");
    // R4 blocked writes
    do_wr(0, 1, 18'h000ee, "R4 load low");
    do_wr(1, 0, 18'h000dd, "R4 enable low");
    do_wr(1, 1, 18'h00011, "R4 pointer held, full written");
    // R7 read pointer independent: it sits at empty
    do_rd(1, 1, 0, "R7 read ptr unaffected by writes");
    // R8 fwft blocks, pointer held
    do_rd(1, 1, 1, "R8 fwft blocked");
    do_rd(1, 1, 0, "R8 ptr held after fwft");
    // R9 idle reads
    do_rd(0, 1, 0, "R9 load low");
    do_rd(1, 0, 0, "R9 enable low");
    do_rd(1, 1, 0, "R6 wrap read");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic ld, en, fw;
      ld = ($urandom % 4) != 0;
      en = ($urandom % 4) != 0;
      fw = ($urandom % 5) == 0;
      if ($urandom % 2) do_wr(ld, en, DW'($urandom), "R2 R3 R4 random write");
      else              do_rd(ld, en, fw, "R5 R6 R8 R9 random read");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule